// File: doc/BRIEF.md
# DDR2 Power-Up Initialisation Sequencer

This block brings one or two ranks of DDR2 memory out of power-up. It waits for the PHY delay line to report lock. It then holds off for the stable-clock period. After that it issues the fixed DDR2 bring-up command list to each rank in turn, through a valid/ready command port. It inserts the mandatory idle periods between the steps that need them. All idle periods are given in clock cycles, derived from a clock-frequency parameter. The mode-register values are parameters.

The periodic refresh generator sits downstream. It is held disabled (`refresh_en` low) until the last command of the last rank has been accepted. It then receives its enable and the refresh interval count. One cycle later `init_done` rises and stays high until reset.

The command port follows valid/ready rules. `cmd_valid` rises with a command and stays high, with every field frozen, until a cycle in which `cmd_ready` is also high. That cycle transfers exactly one command. The downstream side may hold `cmd_ready` low for any number of cycles. Back-pressure delays the sequence but never reorders, drops or repeats a command.

Top module: `ddr2_init_seq`

## Requirements
- R1: No command is presented before `dll_locked` has been sampled high. After the first cycle in which it is sampled high, `cmd_valid` stays low for exactly PWRUP_US × CLK_MHZ cycles (40000 by default) and rises in the cycle after that.
- R2: Each rank receives 12 commands, in this order: NOP, precharge-all, EMR2 write, EMR3 write, EMR1 write (0x400, DLL on), MR write (0x542, DLL reset), precharge-all, refresh, refresh, MR write (0x442, no DLL reset), EMR1 write (0x780, OCD default), EMR1 write (0x400, OCD exit). The `cmd_kind` codes are 0x7 for NOP, 0x1 for precharge-all, 0x5 for refresh and 0x0 for a mode-register write. The `cmd_mrsel` values are 0 for MR, 1 for EMR1, 2 for EMR2 and 3 for EMR3, and are 0 for all other kinds. Both EMR2 and EMR3 carry address 0.
- R3: After a NOP is accepted, `cmd_valid` stays low for exactly ceil(400 ns × CLK_MHZ) cycles (80 by default) before the next command.
- R4: After the MR write without DLL reset is accepted, `cmd_valid` stays low for exactly MRS_WAIT_CLK cycles (200 by default).
- R5: After any other accepted command, including the last command of rank 0, the next command is presented in the very next cycle.
- R6: While `cmd_valid` is high and `cmd_ready` is low, the next cycle still has `cmd_valid` high with all command fields unchanged. Each handshake transfers exactly one command.
- R7: With NUM_RANKS = 2, the first 12 commands carry `cmd_cs` = 0 and the next 12 carry `cmd_cs` = 1. No other commands are issued.
- R8: `refresh_en` is low from reset through the final accepted command. It rises in the cycle after that handshake and stays high.
- R9: `init_done` rises one cycle after `refresh_en` and stays high until reset. No command is presented after it.
- R10: `refi_cycles` equals 7.8 µs × CLK_MHZ, which is 0x618 at 200 MHz.
- R11: Once the sequence has started, a later low level on `dll_locked` has no effect on the commands or their timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dll_locked | input | 1 | PHY delay line locked; starts the sequence |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Downstream accepts the command this cycle |
| cmd_kind | output | 4 | Command code (0x7 NOP, 0x1 precharge-all, 0x5 refresh, 0x0 mode write) |
| cmd_cs | output | RANK_W (1) | Target rank |
| cmd_mrsel | output | 2 | Mode register select |
| cmd_addr | output | ADDR_W (14) | Mode register value / address |
| refresh_en | output | 1 | Enables the periodic refresh generator |
| init_done | output | 1 | Initialisation complete |
| refi_cycles | output | REFI_W (16) | Refresh interval in clock cycles |

## Verification
The assertions assume that `cmd_ready` may take any value in any cycle, independently of `cmd_valid`. They also assume that `dll_locked` may glitch low after it has first been seen high. The stimulus uses a periodic stall pattern on `cmd_ready` that also lands on commands, so the hold rule is exercised. It drops `dll_locked` during the stable-clock wait. Reset is applied only at the start, so the stickiness of `refresh_en` and `init_done` is checked over a single run.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;
  typedef enum logic [3:0] {
    CMD_MRW  = 4'h0,
    CMD_PALL = 4'h1,
    CMD_REF  = 4'h5,
    CMD_NOP  = 4'h7
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PWRUP,
    ST_ISSUE,
    ST_GAP,
    ST_DONE
  } seq_state_e;

  localparam int STEPS_PER_RANK = 12;
  localparam int STEP_W = $clog2(STEPS_PER_RANK);
endpackage

// File: rtl/ddr2_init_step_rom.sv
module ddr2_init_step_rom
  import ddr2_init_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int CNT_W = 16,
  parameter int NOP_GAP = 80,
  parameter int MRS_GAP = 200,
  parameter logic [13:0] MR_DLL_RST = 14'h542,
  parameter logic [13:0] MR_NORMAL = 14'h442,
  parameter logic [13:0] EMR1_DLL_ON = 14'h400,
  parameter logic [13:0] EMR1_OCD_DEF = 14'h780,
  parameter logic [13:0] EMR2_VAL = 14'h000,
  parameter logic [13:0] EMR3_VAL = 14'h000
) (
  input  logic [STEP_W-1:0] step,
  output cmd_e              kind,
  output logic [1:0]        mrsel,
  output logic [ADDR_W-1:0] addr,
  output logic [CNT_W-1:0]  gap_after
);
  // One entry per step: command, target register, value, idle cycles after acceptance.
  always_comb begin
    kind      = CMD_NOP;
    mrsel     = 2'd0;
    addr      = '0;
    gap_after = '0;
    case (step)
      4'd0:  gap_after = CNT_W'(NOP_GAP);
      4'd1:  kind = CMD_PALL;
      4'd2:  begin kind = CMD_MRW; mrsel = 2'd2; addr = ADDR_W'(EMR2_VAL); end
      4'd3:  begin kind = CMD_MRW; mrsel = 2'd3; addr = ADDR_W'(EMR3_VAL); end
      4'd4:  begin kind = CMD_MRW; mrsel = 2'd1; addr = ADDR_W'(EMR1_DLL_ON); end
      4'd5:  begin kind = CMD_MRW; mrsel = 2'd0; addr = ADDR_W'(MR_DLL_RST); end
      4'd6:  kind = CMD_PALL;
      4'd7:  kind = CMD_REF;
      4'd8:  kind = CMD_REF;
      4'd9:  begin
        kind = CMD_MRW; mrsel = 2'd0; addr = ADDR_W'(MR_NORMAL);
        gap_after = CNT_W'(MRS_GAP);
      end
      4'd10: begin kind = CMD_MRW; mrsel = 2'd1; addr = ADDR_W'(EMR1_OCD_DEF); end
      4'd11: begin kind = CMD_MRW; mrsel = 2'd1; addr = ADDR_W'(EMR1_DLL_ON); end
      default: kind = CMD_NOP;
    endcase
  end
endmodule

// File: rtl/ddr2_init_timer.sv
module ddr2_init_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
  import ddr2_init_pkg::*;
#(
  parameter int CLK_MHZ = 200,
  parameter int NUM_RANKS = 2,
  parameter int PWRUP_US = 200,
  parameter int NOP_WAIT_NS = 400,
  parameter int MRS_WAIT_CLK = 200,
  parameter int ADDR_W = 14,
  parameter int REFI_W = 16,
  parameter logic [13:0] MR_DLL_RST = 14'h542,
  parameter logic [13:0] MR_NORMAL = 14'h442,
  parameter logic [13:0] EMR1_DLL_ON = 14'h400,
  parameter logic [13:0] EMR1_OCD_DEF = 14'h780,
  parameter logic [13:0] EMR2_VAL = 14'h000,
  parameter logic [13:0] EMR3_VAL = 14'h000,
  localparam int RANK_W = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dll_locked,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [3:0]        cmd_kind,
  output logic [RANK_W-1:0] cmd_cs,
  output logic [1:0]        cmd_mrsel,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              refresh_en,
  output logic              init_done,
  output logic [REFI_W-1:0] refi_cycles
);
  localparam int PWRUP_CYC = PWRUP_US * CLK_MHZ;
  localparam int NOP_CYC = (NOP_WAIT_NS * CLK_MHZ + 999) / 1000;
  localparam int REFI_CYC = (CLK_MHZ * 78) / 10;
  localparam int SHORT_MAX = (NOP_CYC > MRS_WAIT_CLK) ? NOP_CYC : MRS_WAIT_CLK;
  localparam int WAIT_MAX = (PWRUP_CYC > SHORT_MAX) ? PWRUP_CYC : SHORT_MAX;
  localparam int CNT_W = $clog2(WAIT_MAX + 1);
  localparam int LAST_STEP = STEPS_PER_RANK - 1;

  seq_state_e          state_q;
  logic [STEP_W-1:0]   step_q;
  logic [RANK_W-1:0]   rank_q;
  logic                done_q;
  cmd_e                rom_kind;
  logic [1:0]          rom_mrsel;
  logic [ADDR_W-1:0]   rom_addr;
  logic [CNT_W-1:0]    rom_gap;
  logic                tmr_load;
  logic [CNT_W-1:0]    tmr_val;
  logic                tmr_expired;
  logic                accept;

  ddr2_init_step_rom #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .NOP_GAP(NOP_CYC), .MRS_GAP(MRS_WAIT_CLK),
    .MR_DLL_RST(MR_DLL_RST), .MR_NORMAL(MR_NORMAL), .EMR1_DLL_ON(EMR1_DLL_ON),
    .EMR1_OCD_DEF(EMR1_OCD_DEF), .EMR2_VAL(EMR2_VAL), .EMR3_VAL(EMR3_VAL)
  ) u_rom (
    .step(step_q), .kind(rom_kind), .mrsel(rom_mrsel), .addr(rom_addr), .gap_after(rom_gap)
  );

  ddr2_init_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_expired)
  );

  assign accept = (state_q == ST_ISSUE) && cmd_ready;

  // Timer loads the idle length minus one so the idle state lasts exactly that many cycles.
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (state_q == ST_IDLE && dll_locked) begin
      tmr_load = 1'b1;
      tmr_val  = CNT_W'(PWRUP_CYC - 1);
    end else if (accept && rom_gap != '0) begin
      tmr_load = 1'b1;
      tmr_val  = rom_gap - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      rank_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= (state_q == ST_DONE);
      case (state_q)
        ST_IDLE:  if (dll_locked) state_q <= ST_PWRUP;
        ST_PWRUP: if (tmr_expired) state_q <= ST_ISSUE;
        ST_ISSUE: begin
          if (accept) begin
            if (step_q == STEP_W'(LAST_STEP)) begin
              step_q <= '0;
              if (rank_q == RANK_W'(NUM_RANKS - 1)) state_q <= ST_DONE;
              else rank_q <= rank_q + RANK_W'(1);
            end else begin
              step_q <= step_q + STEP_W'(1);
              if (rom_gap != '0) state_q <= ST_GAP;
            end
          end
        end
        ST_GAP:   if (tmr_expired) state_q <= ST_ISSUE;
        ST_DONE:  state_q <= ST_DONE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_valid   = (state_q == ST_ISSUE);
  assign cmd_kind    = rom_kind;
  assign cmd_cs      = rank_q;
  assign cmd_mrsel   = rom_mrsel;
  assign cmd_addr    = rom_addr;
  assign refresh_en  = (state_q == ST_DONE);
  assign init_done   = done_q;
  assign refi_cycles = REFI_W'(REFI_CYC);
endmodule

// File: rtl/ddr2_init_seq_chk.sv
module ddr2_init_seq_chk #(
  parameter int RANK_W = 1,
  parameter int ADDR_W = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dll_locked,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [3:0]        cmd_kind,
  input logic [RANK_W-1:0] cmd_cs,
  input logic [1:0]        cmd_mrsel,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              refresh_en,
  input logic              init_done
);
  logic lock_seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_seen_q <= 1'b0;
    else if (dll_locked) lock_seen_q <= 1'b1;
  end

  AST_NO_CMD_BEFORE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_seen_q |-> !cmd_valid); // R1
  AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_kind == 4'h0 || cmd_kind == 4'h1 || cmd_kind == 4'h5 || cmd_kind == 4'h7)); // R2
  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_kind) && $stable(cmd_cs)
                                 && $stable(cmd_mrsel) && $stable(cmd_addr)); // R6
  AST_REFRESH_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !refresh_en); // R8
  AST_REFRESH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_en |=> refresh_en); // R8
  AST_DONE_AFTER_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> $past(refresh_en)); // R9
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done); // R9
  AST_NO_CMD_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> !cmd_valid); // R9
endmodule

bind ddr2_init_seq ddr2_init_seq_chk #(.RANK_W(RANK_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dll_locked(dll_locked), .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready), .cmd_kind(cmd_kind), .cmd_cs(cmd_cs), .cmd_mrsel(cmd_mrsel),
  .cmd_addr(cmd_addr), .refresh_en(refresh_en), .init_done(init_done)
);

// File: tb/ddr2_init_seq_tb.sv
`timescale 1ns/1ps
module ddr2_init_seq_tb;
  localparam int PWRUP = 40000;
  localparam int NOPW = 80;
  localparam int MRSW = 200;

  logic clk = 1'b0;
  logic rst_n, dll_locked, cmd_ready;
  logic cmd_valid, refresh_en, init_done;
  logic [3:0] cmd_kind;
  logic [0:0] cmd_cs;
  logic [1:0] cmd_mrsel;
  logic [13:0] cmd_addr;
  logic [15:0] refi_cycles;

  always #2.5 clk = ~clk;

  ddr2_init_seq u_dut (
    .clk(clk), .rst_n(rst_n), .dll_locked(dll_locked), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_kind(cmd_kind), .cmd_cs(cmd_cs), .cmd_mrsel(cmd_mrsel),
    .cmd_addr(cmd_addr), .refresh_en(refresh_en), .init_done(init_done),
    .refi_cycles(refi_cycles)
  );

  typedef struct {
    logic [3:0] kind; logic cs; logic [1:0] sel; logic [13:0] addr; int gap; string req;
  } exp_t;
  exp_t q[$];

  int checks = 0, fails = 0, accepts = 0, idle = 0, post = 0;
  bit lock_mark = 0, lock_raised = 0, stall_prev = 0;
  logic [3:0] p_kind; logic p_cs; logic [1:0] p_sel; logic [13:0] p_addr;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push_cmd(input logic [3:0] k, input logic cs, input logic [1:0] s,
                          input logic [13:0] a, input int gap, input string req);
    exp_t e;
    e.kind = k; e.cs = cs; e.sel = s; e.addr = a; e.gap = gap; e.req = req;
    q.push_back(e);
  endtask

  // gap = idle cycles expected before this command
  task automatic push_rank(input logic cs, input int first_gap, input string first_req);
    push_cmd(4'h7, cs, 2'd0, 14'h000, first_gap, first_req);
    push_cmd(4'h1, cs, 2'd0, 14'h000, NOPW, "R3");
    push_cmd(4'h0, cs, 2'd2, 14'h000, 0, "R5");
    push_cmd(4'h0, cs, 2'd3, 14'h000, 0, "R5");
    push_cmd(4'h0, cs, 2'd1, 14'h400, 0, "R5");
    push_cmd(4'h0, cs, 2'd0, 14'h542, 0, "R5");
    push_cmd(4'h1, cs, 2'd0, 14'h000, 0, "R5");
    push_cmd(4'h5, cs, 2'd0, 14'h000, 0, "R5");
    push_cmd(4'h5, cs, 2'd0, 14'h000, 0, "R5");
    push_cmd(4'h0, cs, 2'd0, 14'h442, 0, "R5");
    push_cmd(4'h0, cs, 2'd1, 14'h780, MRSW, "R4");
    push_cmd(4'h0, cs, 2'd1, 14'h400, 0, "R5");
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (post == 1) begin
        chk("R8", "refresh_en after last accept", refresh_en, 1);
        chk("R9", "init_done one cycle early", init_done, 0);
        post = 2;
      end else if (post == 2) begin
        chk("R9", "init_done after refresh_en", init_done, 1);
        post = 3;
      end
      if (cmd_valid) begin
        if (!lock_raised) chk("R1", "valid before lock", 1, 0);
        if (stall_prev) begin
          chk("R6", "held fields", {p_kind, p_cs, p_sel, p_addr},
              {cmd_kind, cmd_cs[0], cmd_mrsel, cmd_addr});
        end
        if (cmd_ready) begin
          if (q.size() == 0) begin
            chk("R9", "command after sequence", 1, 0);
          end else begin
            exp_t e;
            e = q.pop_front();
            chk("R2", "kind", cmd_kind, e.kind);
            chk("R2", "mode select", cmd_mrsel, e.sel);
            chk("R2", "address", cmd_addr, e.addr);
            chk("R7", "chip select", cmd_cs[0], e.cs);
            chk(e.req, "idle cycles before command", idle, e.gap);
            chk("R8", "refresh_en during sequence", refresh_en, 0);
            if (q.size() == 0) post = 1;
          end
          accepts++;
          idle = 0;
        end
        stall_prev = !cmd_ready;
        p_kind = cmd_kind; p_cs = cmd_cs[0]; p_sel = cmd_mrsel; p_addr = cmd_addr;
      end else begin
        idle++;
        stall_prev = 0;
      end
      if (lock_mark) begin idle = 0; lock_mark = 0; end
    end
  end

  // Ready driver with periodic stalls
  initial begin
    int rcnt = 0;
    cmd_ready = 1'b0;
    forever begin
      @(posedge clk); #1;
      rcnt++;
      cmd_ready = !((rcnt % 7) == 3 || (rcnt % 7) == 4);
    end
  end

  initial begin
    int wd;
    rst_n = 1'b0;
    dll_locked = 1'b0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "reset cmd_valid", cmd_valid, 0);
    chk("R8", "reset refresh_en", refresh_en, 0);
    chk("R9", "reset init_done", init_done, 0);
    chk("R10", "refresh interval", refi_cycles, 16'h618);
    push_rank(1'b0, PWRUP, "R1");
    push_rank(1'b1, 0, "R5");
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk("R1", "no command without lock", cmd_valid, 0);
    @(posedge clk); #1;
    dll_locked = 1'b1; lock_mark = 1; lock_raised = 1;
    repeat (10) @(posedge clk);
    #1 dll_locked = 1'b0; // R11: drop after start, expect no effect
    wd = 0;
    while (!init_done && wd < 60000) begin
      @(posedge clk);
      wd++;
    end
    if (!init_done) begin
      checks++; fails++;
      $display("FAIL R9 watchdog actual=%0d expected=%0d", wd, 0);
    end
    repeat (50) @(posedge clk);
    @(negedge clk);
    chk("R7", "total accepted commands", accepts, 24);
    chk("R11", "sequence completed after lock drop", post, 3);
    chk("R9", "init_done held", init_done, 1);
    chk("R8", "refresh_en held", refresh_en, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule